// File: doc/BRIEF.md
# Parallel Slave Bus Port

This block lets an external microprocessor exchange bytes with a local CPU through one shared byte latch. The external side sees an asynchronous bus with active-low chip select, read strobe and write strobe, plus a split data bus (input, output and an output enable that models the tri-state pad). The local side has a byte write strobe, a byte read strobe and a clear input for the sticky flags.

All bus strobes and the bus data are brought into the local clock domain through two-flop synchronizers. Bus cycles are detected from the synchronized levels, so each bus cycle gives exactly one start and one end event. At the end of a bus write the held byte goes into the latch and the input-full and interrupt flags are raised. During a bus read the latch is driven onto the bus and output-full drops. When the read ends the interrupt flag is raised. A local write during an active read appears on the bus at once but leaves output-full clear. A mode enable gates the whole function: with it low, every flag stays zero and the output enable stays low.

Top module: `psp_port`

## Requirements
- R1: While `mode_en` is 0, `ibf`, `obf`, `irq`, `ovf` and `bus_d_oe` are 0 from the next clock edge on, and bus strobes have no effect.
- R2: A bus write cycle runs while `bus_cs_n` and `bus_wr_n` are both 0. When either returns to 1, the byte driven during the cycle goes into the latch, visible on `cpu_rdata`, and `ibf` and `irq` are set.
- R3: One bus cycle yields exactly one end event, however long it lasts. After `irq` is cleared it stays 0 until another cycle ends.
- R4: A bus read cycle runs while `bus_cs_n` and `bus_rd_n` are both 0. When it begins, `bus_d_oe` goes to 1, `bus_d_out` carries the latch and `obf` is cleared.
- R5: When `bus_cs_n` or `bus_rd_n` returns to 1 after a read, `bus_d_oe` returns to 0 and `irq` is set.
- R6: A local write (`cpu_wr`) outside an active bus read loads the latch and sets `obf` on the same clock edge.
- R7: A local write during an active bus read shows on `bus_d_out` right after that edge, and `obf` stays 0.
- R8: A local read (`cpu_rd`) clears `ibf` on that clock edge.
- R9: A bus write that ends while `ibf` is still 1 sets `ovf`, and `ovf` then stays 1 until it is cleared.
- R10: `clr_flags` clears `irq` and `ovf` on that clock edge, unless a bus cycle ends in the same cycle, in which case the set wins.
- R11: Bus strobe changes take effect on the third rising clock edge after the change: two synchronizer stages and one cycle-detect register.
- R12: With `bus_cs_n` at 1, `bus_rd_n` and `bus_wr_n` start no cycle. The sweep covers all eight strobe combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Enables the port function |
| bus_cs_n | input | 1 | Bus chip select, active low, asynchronous |
| bus_rd_n | input | 1 | Bus read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Bus write strobe, active low, asynchronous |
| bus_d_in | input | 8 | Data from the bus pads |
| bus_d_out | output | 8 | Data to the bus pads (the latch) |
| bus_d_oe | output | 1 | Pad output enable, high only during a bus read |
| cpu_wr | input | 1 | Local byte write strobe |
| cpu_wdata | input | 8 | Local write data |
| cpu_rd | input | 1 | Local byte read strobe, clears input-full |
| cpu_rdata | output | 8 | Latch contents for the local CPU |
| clr_flags | input | 1 | Clears the interrupt and overflow flags |
| ibf | output | 1 | Input buffer full |
| obf | output | 1 | Output buffer full |
| irq | output | 1 | Port interrupt flag |
| ovf | output | 1 | Sticky write overflow flag |

## Verification
Bus strobe results (flags, output enable, latched byte) come due on the third rising edge after the strobe change. Local-side results (`obf`, `ibf`, the latch, the cleared flags) come due on the same edge as the local strobe. The bench changes inputs on falling edges and samples on falling edges. For R11 it checks that the result is still absent after two edges and present after the third. Everywhere else it waits a fixed count at or past the due edge, so every expected value is fixed by the requirement.

// File: rtl/psp_pkg.sv
package psp_pkg;

    typedef struct packed {
        logic ibf;
        logic obf;
        logic irq;
        logic ovf;
    } psp_flags_t;

    typedef struct packed {
        logic wr_end;
        logic rd_start;
        logic rd_end;
        logic rd_act;
    } psp_evt_t;

    // a bus cycle is live while select and its strobe are both low
    function automatic logic cycle_live(input logic cs_n, input logic strobe_n);
        return !cs_n && !strobe_n;
    endfunction

endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= RST_VAL;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/psp_cycle_det.sv
module psp_cycle_det
    import psp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_en,
    input  logic          cs_s,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic [DW-1:0] data_s,
    output psp_evt_t      evt,
    output logic [DW-1:0] wr_byte
);
    logic wr_live, rd_live;
    logic wr_act, rd_act;
    logic [DW-1:0] hold_q;

    assign wr_live = cycle_live(cs_s, wr_s);
    assign rd_live = cycle_live(cs_s, rd_s);

    always_ff @(posedge clk) begin
        if (rst || !mode_en) begin
            wr_act <= 1'b0;
            rd_act <= 1'b0;
        end else begin
            wr_act <= wr_live;
            rd_act <= rd_live;
        end
    end

    // keep the byte seen while the write is live; used at its end
    always_ff @(posedge clk) begin
        if (rst)                     hold_q <= '0;
        else if (wr_live && mode_en) hold_q <= data_s;
    end

    assign evt.wr_end   = wr_act && !wr_live;
    assign evt.rd_start = rd_live && !rd_act && mode_en;
    assign evt.rd_end   = rd_act && !rd_live;
    assign evt.rd_act   = rd_act;
    assign wr_byte      = hold_q;

    p_single_wr_end_r3: assert property (@(posedge clk) disable iff (rst)
        evt.wr_end |=> !evt.wr_end);
    p_single_rd_end_r3: assert property (@(posedge clk) disable iff (rst)
        evt.rd_end |=> !evt.rd_end);
endmodule

// File: rtl/psp_flag_ctrl.sv
module psp_flag_ctrl
    import psp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_en,
    input  psp_evt_t      evt,
    input  logic [DW-1:0] wr_byte,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          clr_flags,
    output psp_flags_t    flags,
    output logic [DW-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst || !mode_en) begin
            flags <= '0;
        end else begin
            if (evt.wr_end)  flags.ibf <= 1'b1;
            else if (cpu_rd) flags.ibf <= 1'b0;

            if (evt.wr_end && flags.ibf && !cpu_rd) flags.ovf <= 1'b1;
            else if (clr_flags)                    flags.ovf <= 1'b0;

            if (evt.wr_end || evt.rd_end) flags.irq <= 1'b1;
            else if (clr_flags)           flags.irq <= 1'b0;

            if (evt.rd_start)                flags.obf <= 1'b0;
            else if (cpu_wr && !evt.rd_act)  flags.obf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         latch_q <= '0;
        else if (evt.wr_end && mode_en)  latch_q <= wr_byte;
        else if (cpu_wr)                 latch_q <= cpu_wdata;
    end

    p_wr_end_flags_r2: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_end && mode_en) |=> (flags.ibf && flags.irq));
    p_rd_start_obf_r4: assert property (@(posedge clk) disable iff (rst)
        evt.rd_start |=> !flags.obf);
    p_rd_end_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_end && mode_en) |=> flags.irq);
    p_wr_in_read_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && evt.rd_act && !evt.wr_end) |=> (!flags.obf && latch_q == $past(cpu_wdata)));
    p_cpu_rd_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !evt.wr_end) |=> !flags.ibf);
    p_no_overflow_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (flags.ovf && !clr_flags && mode_en) |=> flags.ovf);
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_flags && !evt.wr_end && !evt.rd_end) |=> (!flags.irq && !flags.ovf));
endmodule

// File: rtl/psp_port.sv
module psp_port
    import psp_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_en,
    input  logic          bus_cs_n,
    input  logic          bus_rd_n,
    input  logic          bus_wr_n,
    input  logic [DW-1:0] bus_d_in,
    output logic [DW-1:0] bus_d_out,
    output logic          bus_d_oe,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    output logic [DW-1:0] cpu_rdata,
    input  logic          clr_flags,
    output logic          ibf,
    output logic          obf,
    output logic          irq,
    output logic          ovf
);
    localparam int NSTROBE = 3;

    logic [NSTROBE-1:0] strobe_s;
    logic [DW-1:0]      data_s;
    logic [DW-1:0]      wr_byte;
    logic [DW-1:0]      latch_q;
    psp_evt_t           evt;
    psp_flags_t         flags;

    psp_sync #(.W(NSTROBE), .STAGES(SYNC_STAGES), .RST_VAL({NSTROBE{1'b1}})) u_strobe_sync (
        .clk(clk), .rst(rst),
        .d({bus_cs_n, bus_rd_n, bus_wr_n}),
        .q(strobe_s)
    );

    psp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst(rst), .d(bus_d_in), .q(data_s)
    );

    psp_cycle_det #(.DW(DW)) u_det (
        .clk(clk), .rst(rst), .mode_en(mode_en),
        .cs_s(strobe_s[2]), .rd_s(strobe_s[1]), .wr_s(strobe_s[0]),
        .data_s(data_s), .evt(evt), .wr_byte(wr_byte)
    );

    psp_flag_ctrl #(.DW(DW)) u_flags (
        .clk(clk), .rst(rst), .mode_en(mode_en), .evt(evt), .wr_byte(wr_byte),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
        .clr_flags(clr_flags), .flags(flags), .latch_q(latch_q)
    );

    assign bus_d_out = latch_q;
    assign bus_d_oe  = evt.rd_act && mode_en;
    assign cpu_rdata = latch_q;
    assign ibf       = flags.ibf;
    assign obf       = flags.obf;
    assign irq       = flags.irq;
    assign ovf       = flags.ovf;

    p_mode_off_r1: assert property (@(posedge clk) disable iff (rst)
        !mode_en |=> (!ibf && !obf && !irq && !ovf && !bus_d_oe));
    p_oe_needs_sel_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_d_oe) |-> !strobe_s[2]);
endmodule

// File: tb/psp_port_test.sv
module psp_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_en = 1'b1;
    logic       bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [7:0] bus_d_in = '0;
    logic [7:0] bus_d_out;
    logic       bus_d_oe;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, clr_flags = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ibf, obf, irq, ovf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    psp_port uut (
        .clk(clk), .rst(rst), .mode_en(mode_en),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_d_in(bus_d_in), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
        .cpu_rdata(cpu_rdata), .clr_flags(clr_flags),
        .ibf(ibf), .obf(obf), .irq(irq), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [7:0] v);
        cpu_wdata = v; cpu_wr = 1'b1;
        wait_n(1);
        cpu_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        cpu_rd = 1'b1; wait_n(1); cpu_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_flags = 1'b1; wait_n(1); clr_flags = 1'b0;
    endtask

    // starts and ends a bus write; the caller waits for the result
    task automatic bus_write(input logic [7:0] v);
        bus_d_in = v; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        wait_n(4);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        chk("reset ibf", ibf, 0);
        chk("reset obf", obf, 0);
        chk("reset irq", irq, 0);
        chk("reset ovf", ovf, 0);
        chk("reset oe", bus_d_oe, 0);

        // R11 and R2: result due on the third edge after release
        bus_write(8'hA5);
        wait_n(2);
        chk("R11 ibf not yet", ibf, 0);
        wait_n(1);
        chk("R11 ibf on third edge", ibf, 1);
        chk("R2 irq", irq, 1);
        chk("R2 data", cpu_rdata, 8'hA5);

        pulse_clr();
        chk("R10 irq cleared", irq, 0);
        pulse_rd();
        chk("R8 ibf cleared", ibf, 0);

        // R2 and R8 sweep over every byte value
        for (int v = 0; v < 256; v++) begin
            bus_write(v[7:0]);
            wait_n(4);
            chk("R2 sweep data", cpu_rdata, v);
            chk("R2 sweep ibf", ibf, 1);
            pulse_rd();
            chk("R8 sweep ibf", ibf, 0);
        end
        pulse_clr();

        // R9 overflow and stickiness
        bus_write(8'h11); wait_n(4);
        chk("R9 no ovf first", ovf, 0);
        bus_write(8'h22); wait_n(4);
        chk("R9 ovf set", ovf, 1);
        chk("R9 newest data", cpu_rdata, 8'h22);
        pulse_rd();
        wait_n(5);
        chk("R9 ovf sticky", ovf, 1);
        pulse_clr();
        chk("R10 ovf cleared", ovf, 0);
        chk("R10 irq cleared", irq, 0);

        // R3: long write, one event only
        bus_d_in = 8'h77; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        wait_n(20);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        wait_n(3);
        chk("R3 irq once", irq, 1);
        pulse_clr();
        wait_n(6);
        chk("R3 no second event", irq, 0);
        pulse_rd();

        // R6 local write
        pulse_wr(8'h3C);
        chk("R6 obf set", obf, 1);
        chk("R6 oe idle", bus_d_oe, 0);

        // R4 read start, R7 write during read, R5 read end
        bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        wait_n(2);
        chk("R11 oe not yet", bus_d_oe, 0);
        wait_n(1);
        chk("R4 oe", bus_d_oe, 1);
        chk("R4 data out", bus_d_out, 8'h3C);
        chk("R4 obf cleared", obf, 0);
        pulse_wr(8'h5A);
        chk("R7 data out", bus_d_out, 8'h5A);
        chk("R7 obf stays 0", obf, 0);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
        wait_n(3);
        chk("R5 oe released", bus_d_oe, 0);
        chk("R5 irq", irq, 1);
        pulse_clr();

        // R12 sweep of all strobe combinations
        for (int c = 0; c < 8; c++) begin
            logic cs, rd, wr;
            cs = c[2]; rd = c[1]; wr = c[0];
            pulse_rd(); pulse_clr();
            bus_d_in = 8'hC0 + c[7:0];
            bus_cs_n = cs; bus_rd_n = rd; bus_wr_n = wr;
            wait_n(4);
            chk("R12 oe during hold", bus_d_oe, (!cs && !rd));
            bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
            wait_n(4);
            chk("R12 ibf", ibf, (!cs && !wr));
            chk("R12 irq", irq, (!cs && (!wr || !rd)));
        end
        pulse_rd(); pulse_clr();

        // R1 mode disable
        bus_write(8'h99); wait_n(4);
        chk("R1 ibf before", ibf, 1);
        mode_en = 1'b0;
        wait_n(1);
        chk("R1 ibf off", ibf, 0);
        chk("R1 irq off", irq, 0);
        bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        wait_n(5);
        chk("R1 oe off", bus_d_oe, 0);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
        bus_write(8'h44); wait_n(4);
        chk("R1 write ignored", ibf, 0);
        chk("R1 irq ignored", irq, 0);
        pulse_wr(8'h12);
        chk("R1 obf off", obf, 0);
        mode_en = 1'b1;
        wait_n(2);
        chk("R1 ovf off", ovf, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule